// File: doc/BRIEF.md
# Processor bus cycle command controller

This block sits between a 16-bit processor whose bus control is delegated to an external controller and the system bus. It watches the processor's three cycle-type status lines, recognises the start of each bus cycle, and turns the cycle type into separate command strobes. There are strobes for memory read, memory write, I/O read, I/O write and interrupt acknowledge. Each write type has two strobes: an early one that follows read timing, and a late one that waits until write data is valid.

The block also produces the three signals that steer the external address latch and data transceiver: the address latch strobe, the transceiver output enable, and the transceiver direction. When the interrupt controller sits on the local side of the transceiver, the output enable is held off during acknowledge reads and during software poll reads of that controller. This keeps the transceiver from fighting the controller on the data lines.

All outputs are Moore outputs. They are decoded from a registered phase (idle, T1, T2, T3/wait, T4) and from the cycle type latched at cycle start. Every output therefore changes only just after a rising clock edge.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it, every command strobe, `int_vec`, `ale` and `den` are low and `dt_r` is high.
- R2: A cycle starts at the first rising edge where `status` is not 111 and the value sampled at the previous edge was 111. `ale` is then high for exactly that one clock (T1), for every cycle type except halt (011).
- R3: Status codes are 000 acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 code fetch, 101 memory read, 110 memory write, 111 passive. Codes 100/101 drive `mem_rd`, 001 drives `io_rd` and 000 drives `int_ack`. The strobe rises one clock after T1 and stays high for 2+W clocks, where W is the number of T3 edges that sample `ready` low. At most one of these strobes is high at any time.
- R4: For writes, `mem_wr_adv`/`io_wr_adv` follow the read timing of R3. `mem_wr`/`io_wr` rise one clock later and fall together with the advanced strobe.
- R5: `dt_r` is low from T1 to the end of the command for codes 000, 001, 100 and 101. It is high at all other times, including the whole of write cycles.
- R6: `den` is high exactly while the command strobe of a non-halt cycle is high, unless R7 or R8 suppress it.
- R7: With parameter LOCAL_IC=1 (the default), `den` stays low throughout acknowledge cycles.
- R8: An I/O read that starts while `lic_sel` is high keeps `den` low for the whole cycle.
- R9: Halt and passive codes produce no command strobe, no `ale` and no `den`.
- R10: `int_vec` is high with `int_ack` only during the second of two consecutive acknowledge cycles. Any other non-halt cycle restarts the pairing.
- R11: A code held without passing through 111 does not start a new cycle after the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| status | input | 3 | Processor cycle-type status |
| ready | input | 1 | High ends the wait state at the next edge in T3 |
| lic_sel | input | 1 | Cycle addresses the local interrupt controller (poll read) |
| mem_rd | output | 1 | Memory read command |
| mem_wr | output | 1 | Memory write command, late |
| mem_wr_adv | output | 1 | Memory write command, early |
| io_rd | output | 1 | I/O read command |
| io_wr | output | 1 | I/O write command, late |
| io_wr_adv | output | 1 | I/O write command, early |
| int_ack | output | 1 | Interrupt acknowledge command |
| int_vec | output | 1 | Second acknowledge of a pair (vector transfer) |
| ale | output | 1 | Address latch strobe |
| den | output | 1 | Transceiver output enable |
| dt_r | output | 1 | Transceiver direction, 1 = transmit |

## Verification
The status code is driven on a falling edge, and the next rising edge enters T1. `ale` and the `dt_r` drop are then due in the half cycle that follows. Read, early write, `den` and acknowledge strobes are due one edge later. Late writes are due two edges later. The end of the cycle is due at the edge after the one that samples `ready` high. Each scenario task steps the clock edge by edge and samples every output on the falling edge midway through each phase. It compares the full output vector against a phase-indexed expectation, so an early, late, missing or stretched strobe shows up in exactly one named phase.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    localparam int ST_W = 3;

    typedef enum logic [ST_W-1:0] {
        ST_ACK  = 3'b000,
        ST_IORD = 3'b001,
        ST_IOWR = 3'b010,
        ST_HALT = 3'b011,
        ST_CODE = 3'b100,
        ST_MRD  = 3'b101,
        ST_MWR  = 3'b110,
        ST_PASV = 3'b111
    } bus_st_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_T1,
        PH_T2,
        PH_T3,
        PH_T4
    } phase_e;

    typedef struct packed {
        bus_st_e kind;
        logic    lic;
    } cyc_t;

    typedef struct packed {
        logic mrd;
        logic mwr;
        logic mwr_adv;
        logic iord;
        logic iowr;
        logic iowr_adv;
        logic ack;
        logic vec;
        logic ale;
        logic den;
        logic dtr;
    } cmd_t;

    function automatic logic is_mem_read(bus_st_e k);
        return (k == ST_CODE) || (k == ST_MRD);
    endfunction

    function automatic logic is_inbound(bus_st_e k);
        return is_mem_read(k) || (k == ST_IORD) || (k == ST_ACK);
    endfunction

    function automatic logic is_busy(bus_st_e k);
        return (k != ST_HALT) && (k != ST_PASV);
    endfunction

    function automatic logic cmd_phase(phase_e p);
        return (p == PH_T2) || (p == PH_T3);
    endfunction

    function automatic logic dir_phase(phase_e p);
        return (p == PH_T1) || (p == PH_T2) || (p == PH_T3);
    endfunction

endpackage

// File: rtl/bcc_start_detect.sv
module bcc_start_detect
    import bcc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [ST_W-1:0] status,
    output logic            start,
    output bus_st_e         code
);
    bus_st_e prev_q;

    assign code  = bus_st_e'(status);
    assign start = (prev_q == ST_PASV) && (code != ST_PASV);

    always_ff @(posedge clk) begin
        if (rst) prev_q <= ST_PASV;
        else     prev_q <= code;
    end
endmodule

// File: rtl/bcc_cycle_fsm.sv
module bcc_cycle_fsm
    import bcc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  bus_st_e code,
    input  logic    lic_sel,
    input  logic    ready,
    output phase_e  phase,
    output cyc_t    cyc
);
    phase_e ph_q, ph_d;
    cyc_t   cyc_q;
    logic   accept;

    assign accept = start && ((ph_q == PH_IDLE) || (ph_q == PH_T4));

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE: if (accept) ph_d = PH_T1;
            PH_T1:   ph_d = (cyc_q.kind == ST_HALT) ? PH_IDLE : PH_T2;
            PH_T2:   ph_d = PH_T3;
            PH_T3:   if (ready) ph_d = PH_T4;
            PH_T4:   ph_d = accept ? PH_T1 : PH_IDLE;
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q       <= PH_IDLE;
            cyc_q.kind <= ST_PASV;
            cyc_q.lic  <= 1'b0;
        end else begin
            ph_q <= ph_d;
            if (accept) begin
                cyc_q.kind <= code;
                cyc_q.lic  <= lic_sel;
            end
        end
    end

    assign phase = ph_q;
    assign cyc   = cyc_q;
endmodule

// File: rtl/bcc_cmd_decode.sv
module bcc_cmd_decode
    import bcc_pkg::*;
#(
    parameter bit LOCAL_IC = 1'b1
) (
    input  logic   clk,
    input  logic   rst,
    input  phase_e phase,
    input  cyc_t   cyc,
    output cmd_t   cmd
);
    logic second_q;
    logic act, late, hush;

    assign act  = cmd_phase(phase) && is_busy(cyc.kind);
    assign late = (phase == PH_T3);
    assign hush = ((cyc.kind == ST_ACK) && LOCAL_IC) ||
                  ((cyc.kind == ST_IORD) && cyc.lic);

    always_ff @(posedge clk) begin
        if (rst) begin
            second_q <= 1'b0;
        end else if (phase == PH_T4 && cyc.kind == ST_ACK) begin
            second_q <= ~second_q;
        end else if (phase == PH_T1 && cyc.kind != ST_ACK && cyc.kind != ST_HALT) begin
            second_q <= 1'b0;
        end
    end

    always_comb begin
        cmd          = '0;
        cmd.mrd      = act && is_mem_read(cyc.kind);
        cmd.mwr_adv  = act && (cyc.kind == ST_MWR);
        cmd.mwr      = act && late && (cyc.kind == ST_MWR);
        cmd.iord     = act && (cyc.kind == ST_IORD);
        cmd.iowr_adv = act && (cyc.kind == ST_IOWR);
        cmd.iowr     = act && late && (cyc.kind == ST_IOWR);
        cmd.ack      = act && (cyc.kind == ST_ACK);
        cmd.vec      = cmd.ack && second_q;
        cmd.ale      = (phase == PH_T1) && is_busy(cyc.kind);
        cmd.den      = act && !hush;
        cmd.dtr      = !(dir_phase(phase) && is_inbound(cyc.kind));
    end
endmodule

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl
    import bcc_pkg::*;
#(
    parameter bit LOCAL_IC = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [ST_W-1:0] status,
    input  logic            ready,
    input  logic            lic_sel,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            mem_wr_adv,
    output logic            io_rd,
    output logic            io_wr,
    output logic            io_wr_adv,
    output logic            int_ack,
    output logic            int_vec,
    output logic            ale,
    output logic            den,
    output logic            dt_r
);
    logic    start;
    bus_st_e code;
    phase_e  phase;
    cyc_t    cyc;
    cmd_t    cmd;

    bcc_start_detect u_det (
        .clk    (clk),
        .rst    (rst),
        .status (status),
        .start  (start),
        .code   (code)
    );

    bcc_cycle_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .code    (code),
        .lic_sel (lic_sel),
        .ready   (ready),
        .phase   (phase),
        .cyc     (cyc)
    );

    bcc_cmd_decode #(.LOCAL_IC(LOCAL_IC)) u_dec (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .cyc   (cyc),
        .cmd   (cmd)
    );

    assign mem_rd     = cmd.mrd;
    assign mem_wr     = cmd.mwr;
    assign mem_wr_adv = cmd.mwr_adv;
    assign io_rd      = cmd.iord;
    assign io_wr      = cmd.iowr;
    assign io_wr_adv  = cmd.iowr_adv;
    assign int_ack    = cmd.ack;
    assign int_vec    = cmd.vec;
    assign ale        = cmd.ale;
    assign den        = cmd.den;
    assign dt_r       = cmd.dtr;
endmodule

// File: rtl/bus_cmd_ctrl_chk.sv
module bus_cmd_ctrl_chk #(
    parameter bit LOCAL_IC = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic [2:0] status,
    input logic       ready,
    input logic       lic_sel,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       mem_wr_adv,
    input logic       io_rd,
    input logic       io_wr,
    input logic       io_wr_adv,
    input logic       int_ack,
    input logic       int_vec,
    input logic       ale,
    input logic       den,
    input logic       dt_r
);
    AST_CMD_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr_adv, io_rd, io_wr_adv, int_ack})); // R3
    AST_ALE_PULSE: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale); // R2
    AST_ALE_BEFORE_CMD: assert property (@(posedge clk) disable iff (rst)
        ale |-> !(mem_rd || io_rd || int_ack || mem_wr_adv || io_wr_adv)); // R2
    AST_MWR_LATE: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_wr) |-> $past(mem_wr_adv)); // R4
    AST_IOWR_LATE: assert property (@(posedge clk) disable iff (rst)
        $rose(io_wr) |-> $past(io_wr_adv)); // R4
    AST_DIR_RX: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || io_rd || int_ack) |-> !dt_r); // R5
    AST_DIR_TX: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_adv || io_wr_adv) |-> dt_r); // R5
    AST_DEN_WITH_CMD: assert property (@(posedge clk) disable iff (rst)
        den |-> (mem_rd || io_rd || int_ack || mem_wr_adv || io_wr_adv)); // R6
    AST_VEC_IN_ACK: assert property (@(posedge clk) disable iff (rst)
        int_vec |-> int_ack); // R10

    generate
        if (LOCAL_IC) begin : g_local
            AST_DEN_ACK_OFF: assert property (@(posedge clk) disable iff (rst)
                int_ack |-> !den); // R7
        end
    endgenerate
endmodule

bind bus_cmd_ctrl bus_cmd_ctrl_chk #(.LOCAL_IC(LOCAL_IC)) u_chk (.*);

// File: tb/tb_bus_cmd_ctrl.sv
module tb_bus_cmd_ctrl;
    localparam bit LOCAL_IC = 1'b1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] status = 3'b111;
    logic       ready = 1'b0;
    logic       lic_sel = 1'b0;
    logic mem_rd, mem_wr, mem_wr_adv, io_rd, io_wr, io_wr_adv;
    logic int_ack, int_vec, ale, den, dt_r;

    int total = 0;
    int bad = 0;
    bit pair_second = 1'b0;

    always #10 clk = ~clk;

    bus_cmd_ctrl #(.LOCAL_IC(LOCAL_IC)) dut (
        .clk(clk), .rst(rst), .status(status), .ready(ready), .lic_sel(lic_sel),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wr_adv(mem_wr_adv),
        .io_rd(io_rd), .io_wr(io_wr), .io_wr_adv(io_wr_adv),
        .int_ack(int_ack), .int_vec(int_vec), .ale(ale), .den(den), .dt_r(dt_r)
    );

    // order: mrd mwr_adv mwr iord iowr_adv iowr ack vec ale den dtr
    function automatic logic [10:0] expect_out(input logic [2:0] c, input int ph,
                                               input bit lic, input bit vec);
        logic rd, act, ack, hush;
        rd   = (c == 3'b100) || (c == 3'b101);
        act  = (ph == 2) || (ph == 3);
        ack  = act && (c == 3'b000);
        hush = ((c == 3'b000) && LOCAL_IC) || ((c == 3'b001) && lic);
        return {act && rd,
                act && (c == 3'b110), (ph == 3) && (c == 3'b110),
                act && (c == 3'b001),
                act && (c == 3'b010), (ph == 3) && (c == 3'b010),
                ack, ack && vec,
                (ph == 1) && (c != 3'b011) && (c != 3'b111),
                act && (c != 3'b011) && (c != 3'b111) && !hush,
                !((ph >= 1) && (ph <= 3) && (rd || c == 3'b001 || c == 3'b000))};
    endfunction

    function automatic logic [10:0] actual_out();
        return {mem_rd, mem_wr_adv, mem_wr, io_rd, io_wr_adv, io_wr,
                int_ack, int_vec, ale, den, dt_r};
    endfunction

    task automatic check(input logic [10:0] exp, input string req, input string what);
        logic [10:0] got;
        got = actual_out();
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // one full bus cycle; caller is at a negedge with status passive
    task automatic run_cycle(input logic [2:0] c, input int waits, input bit lic,
                             input bit to_pasv, input string req);
        bit vec;
        vec = (c == 3'b000) ? pair_second : 1'b0;
        status  = c;
        lic_sel = lic;
        ready   = 1'b0;
        step();
        check(expect_out(c, 1, lic, vec), req, "T1");
        if (c == 3'b011) begin
            for (int i = 0; i < 3; i++) begin
                step();
                check(expect_out(c, 0, lic, vec), "R9", "halt hold");
            end
            status = 3'b111;
            step();
            check(expect_out(3'b111, 0, 1'b0, 1'b0), "R9", "passive after halt");
            return;
        end
        step();
        check(expect_out(c, 2, lic, vec), req, "T2");
        for (int i = 0; i <= waits; i++) begin
            step();
            check(expect_out(c, 3, lic, vec), req, "T3/wait");
            if (i == waits) begin
                ready = 1'b1;
                if (to_pasv) status = 3'b111;
            end
        end
        step();
        ready = 1'b0;
        check(expect_out(c, 4, lic, vec), req, "T4");
        step();
        check(expect_out(c, 0, lic, vec), req, "idle after cycle");
        if (c == 3'b000) pair_second = !pair_second;
        else pair_second = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) step();
        check(11'b00000000001, "R1", "in reset");
        rst = 1'b0;
        step();
        check(11'b00000000001, "R1", "after reset");
    endtask

    task automatic t_reads();
        run_cycle(3'b100, 0, 1'b0, 1'b1, "R3 code fetch");
        run_cycle(3'b101, 2, 1'b0, 1'b1, "R3 memory read");
        run_cycle(3'b001, 1, 1'b0, 1'b1, "R6 I/O read");
    endtask

    task automatic t_writes();
        run_cycle(3'b110, 0, 1'b0, 1'b1, "R4 memory write");
        run_cycle(3'b110, 3, 1'b0, 1'b1, "R4 memory write waits");
        run_cycle(3'b010, 1, 1'b0, 1'b1, "R5 I/O write");
    endtask

    task automatic t_ack_pair();
        run_cycle(3'b000, 0, 1'b0, 1'b1, "R7 ack first");
        run_cycle(3'b000, 1, 1'b0, 1'b1, "R10 ack second");
        run_cycle(3'b101, 0, 1'b0, 1'b1, "R10 break pair");
        run_cycle(3'b000, 0, 1'b0, 1'b1, "R10 ack first again");
    endtask

    task automatic t_poll();
        run_cycle(3'b001, 0, 1'b1, 1'b1, "R8 poll read");
        run_cycle(3'b001, 0, 1'b0, 1'b1, "R6 plain I/O read");
    endtask

    task automatic t_halt_passive();
        run_cycle(3'b011, 0, 1'b0, 1'b1, "R9 halt");
        for (int i = 0; i < 3; i++) begin
            step();
            check(expect_out(3'b111, 0, 1'b0, 1'b0), "R9", "passive idle");
        end
    endtask

    task automatic t_hold();
        run_cycle(3'b101, 0, 1'b0, 1'b0, "R11 held read");
        for (int i = 0; i < 3; i++) begin
            step();
            check(expect_out(3'b101, 0, 1'b0, 1'b0), "R11", "held code no restart");
        end
        status = 3'b111;
        step();
        run_cycle(3'b110, 0, 1'b0, 1'b1, "R2 start after passive");
    endtask

    initial begin
        @(negedge clk);
        fork
            begin
                t_reset();
                t_reads();
                t_writes();
                t_ack_pair();
                t_poll();
                t_halt_passive();
                t_hold();
            end
            begin
                repeat (20000) @(posedge clk);
                bad++;
                total++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule